// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This controller walks a multi-register load or store. When `start` is seen while it is idle, it captures a register bit mask, a base address and the addressing controls. It then issues one word-sized bus request for each set bit in the mask. Each request carries an address, a sequential/nonsequential attribute, the register index it serves and a read/write direction.

Requests go out in ascending register order. Each one is held until the memory side returns `bus_ack`. The start address is derived from the number of set bits, so all four addressing orders (increment after, increment before, decrement before, decrement after) leave memory in the same register layout. Alongside the transfers the block produces the updated base value for writeback. It times that update differently for loads and stores. It also drives the user-bank and status-restore controls that the privileged variant of the transfer needs.

The register file and the memory are outside the block. They act on the indices and strobes it emits.

Top module: `blk_xfer_seq`

## Requirements
- R1: With N the number of set mask bits and W the word size in bytes, the first request address is: base when pre_idx=0 and up_dir=1; base+W when pre_idx=1 and up_dir=1; base−W·N when pre_idx=1 and up_dir=0; base−W·N+W when pre_idx=0 and up_dir=0. All arithmetic wraps modulo 2^AW.
- R2: Register indices are served lowest first. Each acknowledged request is followed by the next set index at an address W higher.
- R3: `bus_seq` is 0 on the first request of an operation and 1 on every later request.
- R4: When wb_en=1 and the mask is non-empty, `wb_valid` pulses for exactly one cycle. Its `wb_value` is base+W·N when up_dir=1 and base−W·N when up_dir=0. When wb_en=0, no pulse occurs.
- R5: For a load (is_load=1), the writeback pulse comes before the first request. For a store, it comes after the last request is acknowledged.
- R6: `user_bank` is 1 on every request when s_bit=1 and the operation is either a store or a load whose mask has bit NREG−1 clear. Otherwise it is 0 on every request. It is 0 again when `done` is raised.
- R7: `status_restore` pulses once, in the load's idle cycle, exactly when s_bit=1, is_load=1, mask bit NREG−1 is set and usr_or_sys=0. Otherwise it stays 0.
- R8: A load with a non-empty mask spends one cycle with `idle_cycle`=1 after its last acknowledged request and before `done`. A store never raises `idle_cycle` and raises `fetch_nseq` together with `done`.
- R9: A request holds its address, index and attributes while `bus_ack` is 0. `bus_write` is the inverse of is_load.
- R10: An empty mask makes no request and raises `done` in the cycle after `start`.
- R11: `done` is a single-cycle pulse. `busy` is 1 from the cycle after `start` until `done`, and no request coincides with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| reg_mask | input | NREG | Register bit mask, bit i selects register i |
| base | input | AW | Base register value |
| pre_idx | input | 1 | Adjust address before each access |
| up_dir | input | 1 | Ascending (1) or descending (0) addressing |
| wb_en | input | 1 | Write the updated base back |
| s_bit | input | 1 | Privileged variant: user bank or status restore |
| is_load | input | 1 | 1 = load, 0 = store |
| usr_or_sys | input | 1 | Current mode is one without a saved status |
| bus_ack | input | 1 | Memory accepted the current request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| bus_req | output | 1 | Word request valid |
| bus_addr | output | AW | Request address |
| bus_seq | output | 1 | Request is sequential to the previous one |
| bus_write | output | 1 | Request writes memory |
| bus_reg_idx | output | $clog2(NREG) | Register served by the request |
| wb_valid | output | 1 | Base writeback strobe |
| wb_value | output | AW | Updated base value |
| user_bank | output | 1 | Use the user-mode register bank |
| status_restore | output | 1 | Copy saved status into current status |
| idle_cycle | output | 1 | Internal cycle after a load |
| fetch_nseq | output | 1 | Next instruction fetch is nonsequential |

## Verification
The bench builds the block with its defaults: sixteen mask bits, 32-bit addresses and 4-byte words. With sixteen bits, the top-register rules for the user bank and the status restore can be reached, and so can a full mask with N=16. The 32-bit width lets directed bases near zero and near the top of the address space exercise wrap-around in the descending and ascending start and writeback arithmetic. Random masks, modes and acknowledge delays cover the ordering and hold behaviour across all four addressing orders.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_WB,
        ST_XFER,
        ST_IDLE_CYC,
        ST_POST_WB,
        ST_DONE
    } xfer_state_e;
endpackage

// File: rtl/xfer_popcount.sv
module xfer_popcount #(
    parameter int NREG = 16,
    localparam int CW = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] vec,
    output logic [CW-1:0]   count
);
    logic [CW-1:0] part [NREG+1];

    assign part[0] = '0;
    for (genvar i = 0; i < NREG; i++) begin : g_sum
        assign part[i+1] = part[i] + {{(CW-1){1'b0}}, vec[i]};
    end
    assign count = part[NREG];
endmodule

// File: rtl/xfer_addr_calc.sv
module xfer_addr_calc #(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic          pre_idx,
    input  logic          up_dir,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] wb_addr
);
    localparam logic [AW-1:0] WORD = AW'(WORD_BYTES);

    logic [AW-1:0] span;

    always_comb begin
        span = AW'(count) * WORD;
        case ({pre_idx, up_dir})
            2'b01:   start_addr = base;
            2'b11:   start_addr = base + WORD;
            2'b10:   start_addr = base - span;
            default: start_addr = base - span + WORD;
        endcase
        wb_addr = up_dir ? base + span : base - span;
    end
endmodule

// File: rtl/xfer_lowest.sv
module xfer_lowest #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] vec,
    output logic [IW-1:0]   idx,
    output logic [NREG-1:0] rest
);
    logic [NREG-1:0] onehot;

    always_comb begin
        onehot = vec & (~vec + NREG'(1));
        rest   = vec & ~onehot;
        idx    = '0;
        for (int i = 0; i < NREG; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import xfer_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] reg_mask,
    input  logic [AW-1:0]   base,
    input  logic            pre_idx,
    input  logic            up_dir,
    input  logic            wb_en,
    input  logic            s_bit,
    input  logic            is_load,
    input  logic            usr_or_sys,
    input  logic            bus_ack,
    output logic            busy,
    output logic            done,
    output logic            bus_req,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_seq,
    output logic            bus_write,
    output logic [IW-1:0]   bus_reg_idx,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_value,
    output logic            user_bank,
    output logic            status_restore,
    output logic            idle_cycle,
    output logic            fetch_nseq
);
    localparam int CW = $clog2(NREG + 1);
    localparam logic [AW-1:0] WORD = AW'(WORD_BYTES);

    typedef struct packed {
        xfer_state_e     state;
        logic [NREG-1:0] mask;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   wb_addr;
        logic            first;
        logic            load;
        logic            wb;
        logic            ubank;
        logic            restore;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [CW-1:0]   mask_cnt;
    logic [AW-1:0]   calc_start;
    logic [AW-1:0]   calc_wb;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] mask_rest;

    xfer_popcount #(.NREG(NREG)) u_pop (
        .vec   (reg_mask),
        .count (mask_cnt)
    );

    xfer_addr_calc #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .base       (base),
        .count      (mask_cnt),
        .pre_idx    (pre_idx),
        .up_dir     (up_dir),
        .start_addr (calc_start),
        .wb_addr    (calc_wb)
    );

    xfer_lowest #(.NREG(NREG)) u_low (
        .vec  (q.mask),
        .idx  (cur_idx),
        .rest (mask_rest)
    );

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.mask    = reg_mask;
                    d.addr    = calc_start;
                    d.wb_addr = calc_wb;
                    d.first   = 1'b1;
                    d.load    = is_load;
                    d.wb      = wb_en;
                    d.ubank   = s_bit & (~is_load | ~reg_mask[NREG-1]);
                    d.restore = s_bit & is_load & reg_mask[NREG-1] & ~usr_or_sys;
                    if (reg_mask == '0)
                        d.state = ST_DONE;
                    else if (is_load && wb_en)
                        d.state = ST_PRE_WB;
                    else
                        d.state = ST_XFER;
                end
            end
            ST_PRE_WB: d.state = ST_XFER;
            ST_XFER: begin
                if (bus_ack) begin
                    d.mask  = mask_rest;
                    d.addr  = q.addr + WORD;
                    d.first = 1'b0;
                    if (mask_rest == '0) begin
                        if (q.load)
                            d.state = ST_IDLE_CYC;
                        else if (q.wb)
                            d.state = ST_POST_WB;
                        else
                            d.state = ST_DONE;
                    end
                end
            end
            ST_IDLE_CYC: d.state = ST_DONE;
            ST_POST_WB:  d.state = ST_DONE;
            ST_DONE:     d.state = ST_IDLE;
            default:     d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.mask    <= '0;
            q.addr    <= '0;
            q.wb_addr <= '0;
            q.first   <= 1'b1;
            q.load    <= 1'b0;
            q.wb      <= 1'b0;
            q.ubank   <= 1'b0;
            q.restore <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy           = (q.state == ST_PRE_WB) || (q.state == ST_XFER) ||
                            (q.state == ST_IDLE_CYC) || (q.state == ST_POST_WB);
    assign done           = (q.state == ST_DONE);
    assign bus_req        = (q.state == ST_XFER);
    assign bus_addr       = q.addr;
    assign bus_seq        = ~q.first;
    assign bus_write      = ~q.load;
    assign bus_reg_idx    = cur_idx;
    assign wb_valid       = (q.state == ST_PRE_WB) || (q.state == ST_POST_WB);
    assign wb_value       = q.wb_addr;
    assign user_bank      = busy & q.ubank;
    assign idle_cycle     = (q.state == ST_IDLE_CYC);
    assign status_restore = (q.state == ST_IDLE_CYC) & q.restore;
    assign fetch_nseq     = (q.state == ST_DONE) & ~q.load & ~q.first;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int IW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [NREG-1:0] reg_mask,
    input logic            busy,
    input logic            done,
    input logic            bus_req,
    input logic            bus_ack,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_seq,
    input logic            bus_write,
    input logic [IW-1:0]   bus_reg_idx,
    input logic            wb_valid,
    input logic            status_restore,
    input logic            idle_cycle
);
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req || bus_addr == $past(bus_addr) + AW'(WORD_BYTES)));

    assert_idx_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req || bus_reg_idx > $past(bus_reg_idx)));

    assert_later_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req || bus_seq));

    assert_restore_in_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_restore |-> idle_cycle);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_reg_idx) && $stable(bus_write) && $stable(bus_seq)));

    assert_empty_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && reg_mask == '0) |=> (done && !bus_req));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, bus_req, wb_valid, idle_cycle}));

    assert_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);
endmodule

bind blk_xfer_seq xfer_seq_chk #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .reg_mask       (reg_mask),
    .busy           (busy),
    .done           (done),
    .bus_req        (bus_req),
    .bus_ack        (bus_ack),
    .bus_addr       (bus_addr),
    .bus_seq        (bus_seq),
    .bus_write      (bus_write),
    .bus_reg_idx    (bus_reg_idx),
    .wb_valid       (wb_valid),
    .status_restore (status_restore),
    .idle_cycle     (idle_cycle)
);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
    localparam int NREG = 16;
    localparam int AW   = 32;
    localparam int WB   = 4;
    localparam int IW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NREG-1:0] reg_mask = '0;
    logic [AW-1:0]   base = '0;
    logic            pre_idx = 1'b0, up_dir = 1'b0, wb_en = 1'b0, s_bit = 1'b0;
    logic            is_load = 1'b0, usr_or_sys = 1'b0, bus_ack = 1'b0;
    logic            busy, done, bus_req, bus_seq, bus_write, wb_valid;
    logic            user_bank, status_restore, idle_cycle, fetch_nseq;
    logic [AW-1:0]   bus_addr, wb_value;
    logic [IW-1:0]   bus_reg_idx;

    int total = 0;
    int bad   = 0;
    bit hung  = 0;

    always #2.5 clk = ~clk;

    blk_xfer_seq #(.NREG(NREG), .AW(AW), .WORD_BYTES(WB)) u_blk_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask), .base(base),
        .pre_idx(pre_idx), .up_dir(up_dir), .wb_en(wb_en), .s_bit(s_bit),
        .is_load(is_load), .usr_or_sys(usr_or_sys), .bus_ack(bus_ack),
        .busy(busy), .done(done), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_seq(bus_seq), .bus_write(bus_write), .bus_reg_idx(bus_reg_idx),
        .wb_valid(wb_valid), .wb_value(wb_value), .user_bank(user_bank),
        .status_restore(status_restore), .idle_cycle(idle_cycle), .fetch_nseq(fetch_nseq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [NREG-1:0] m);
        int c = 0;
        for (int i = 0; i < NREG; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [AW-1:0] exp_start(input logic [AW-1:0] b, input logic p,
                                                input logic u, input int n);
        logic [AW-1:0] span = AW'(n * WB);
        if (!p && u) return b;
        if (p && u)  return b + AW'(WB);
        if (p && !u) return b - span;
        return b - span + AW'(WB);
    endfunction

    function automatic logic [AW-1:0] exp_wb(input logic [AW-1:0] b, input logic u, input int n);
        return u ? b + AW'(n * WB) : b - AW'(n * WB);
    endfunction

    task automatic run_op(input logic [NREG-1:0] m, input logic [AW-1:0] b, input logic p,
                          input logic u, input logic w, input logic s, input logic ld,
                          input logic us);
        int n = popc(m);
        logic [AW-1:0] st = exp_start(b, p, u, n);
        logic [NREG-1:0] rem = m;
        bit exp_ub = s && (!ld || !m[NREG-1]);
        bit exp_rs = s && ld && m[NREG-1] && !us;
        int ntx = 0, wb_cnt = 0, wb_pos = -1, idle_cnt = 0, idle_pos = -1, rs_cnt = 0;
        int cyc = 0;
        bit finished = 0, req_ok = 1, nseq_ok = 1;
        int exp_idx;
        @(negedge clk);
        reg_mask = m; base = b; pre_idx = p; up_dir = u; wb_en = w;
        s_bit = s; is_load = ld; usr_or_sys = us; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!finished && cyc < 300) begin
            if (done) begin
                finished = 1;
                if (n == 0) chk(cyc == 0, "R10 done latency", 64'(cyc), 0);
                chk(user_bank == 1'b0, "R6 user_bank at done", 64'(user_bank), 0);
                chk(fetch_nseq == (!ld && n > 0), "R8 fetch_nseq", 64'(fetch_nseq), 64'(!ld && n > 0));
                chk(busy == 1'b0, "R11 busy at done", 64'(busy), 0);
            end else if (n > 0) begin
                if (!busy) nseq_ok = 0;
            end
            if (wb_valid) begin
                wb_cnt++;
                wb_pos = ntx;
                chk(wb_value == exp_wb(b, u, n), "R4 wb_value", 64'(wb_value), 64'(exp_wb(b, u, n)));
            end
            if (idle_cycle) begin
                idle_cnt++;
                idle_pos = ntx;
            end
            if (status_restore) rs_cnt++;
            if (bus_req) begin
                exp_idx = 0;
                for (int i = NREG - 1; i >= 0; i--) if (rem[i]) exp_idx = i;
                if (bus_addr != st + AW'(ntx * WB)) begin
                    req_ok = 0;
                    chk(0, ntx == 0 ? "R1 start address" : "R2 address step",
                        64'(bus_addr), 64'(st + AW'(ntx * WB)));
                end
                if (int'(bus_reg_idx) != exp_idx) begin
                    req_ok = 0;
                    chk(0, "R2 register order", 64'(bus_reg_idx), 64'(exp_idx));
                end
                if (bus_seq != (ntx != 0)) begin
                    req_ok = 0;
                    chk(0, "R3 seq attribute", 64'(bus_seq), 64'(ntx != 0));
                end
                if (bus_write != !ld || user_bank != exp_ub) begin
                    req_ok = 0;
                    chk(0, "R9/R6 write or user_bank", 64'({bus_write, user_bank}), 64'({!ld, exp_ub}));
                end
                bus_ack = ($urandom % 3) != 0;
                if (bus_ack) begin
                    ntx++;
                    rem[exp_idx] = 1'b0;
                end
            end else begin
                bus_ack = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        bus_ack = 1'b0;
        if (!finished) begin
            hung = 1;
            chk(0, "R11 operation never finished", 64'(cyc), 0);
            return;
        end
        chk(req_ok, "R1 R2 R3 R9 request stream", 64'(req_ok), 1);
        chk(ntx == n, "R2 transfer count", 64'(ntx), 64'(n));
        chk(nseq_ok, "R11 busy throughout", 64'(nseq_ok), 1);
        chk(wb_cnt == ((w && n > 0) ? 1 : 0), "R4 writeback count", 64'(wb_cnt), 64'((w && n > 0) ? 1 : 0));
        if (w && n > 0)
            chk(wb_pos == (ld ? 0 : n), "R5 writeback timing", 64'(wb_pos), 64'(ld ? 0 : n));
        chk(idle_cnt == ((ld && n > 0) ? 1 : 0), "R8 idle cycle count", 64'(idle_cnt), 64'((ld && n > 0) ? 1 : 0));
        if (ld && n > 0) chk(idle_pos == n, "R8 idle after last", 64'(idle_pos), 64'(n));
        chk(rs_cnt == ((exp_rs && n > 0) ? 1 : 0), "R7 status restore", 64'(rs_cnt), 64'((exp_rs && n > 0) ? 1 : 0));
    endtask

    initial begin
        #400000;
        hung = 1;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_req && !wb_valid, "R11 reset state",
            64'({busy, done, bus_req, wb_valid}), 0);
        // directed corners
        run_op(16'h0000, 32'h100, 1, 1, 1, 0, 1, 0);          // R10 empty mask
        run_op(16'hFFFF, 32'h0000_0000, 1, 0, 1, 0, 1, 0);    // R1 DB wrap below zero
        run_op(16'h8001, 32'hFFFF_FFF8, 0, 1, 1, 0, 0, 0);    // R1 IA wrap at top, store
        run_op(16'h00F0, 32'h2000, 0, 0, 1, 0, 1, 0);         // R1 DA
        run_op(16'h0102, 32'h3000, 1, 1, 1, 0, 0, 0);         // R1 IB store, R5
        run_op(16'h800F, 32'h4000, 0, 1, 0, 1, 1, 0);         // R7 restore
        run_op(16'h800F, 32'h4000, 0, 1, 0, 1, 1, 1);         // R7 suppressed in usr/sys
        run_op(16'h000F, 32'h4000, 0, 1, 1, 1, 1, 0);         // R6 load without top reg
        run_op(16'h8000, 32'h5000, 1, 0, 1, 1, 0, 0);         // R6 store with S
        run_op(16'h0001, 32'h6000, 0, 0, 0, 0, 0, 0);         // single store
        for (int k = 0; k < 60 && !hung; k++) begin
            logic [NREG-1:0] m = NREG'($urandom);
            if (k % 7 == 0) m = m & NREG'($urandom);
            run_op(m, $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule